// File: doc/BRIEF.md
# Gated Up/Down Counter Channel with Latch Capture

This block is one counting channel. It keeps a 32-bit count that moves up or down by one on each count strobe from an upstream quadrature or pulse decoder, but only while its internal gate is open. The internal gate combines two sources: a software gate bit held in a control register, and a hardware gate pin. A configuration bit can take the hardware pin out of the gate, so that the software bit alone opens or closes counting.

A separate latch pin takes a snapshot of the count on each of its rising edges, so a measurement can be frozen while counting goes on. Both pins come from outside the clock domain and pass through synchronizer chains before any logic sees them. A synchronous load presets the count to a start value. The channel drives the live count, the latched value, a one-cycle capture pulse and the current gate state. All of these are plain control and status pins. No data stream here needs a valid/ready handshake, so none is present.

Top module: `gated_counter_channel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `count` and `latch_value` are 0 and `latch_event` is 0.
- R2: With `hw_gate_en`=1, `gate_open` is 1 exactly when `sw_gate`=1 and the synchronized hardware gate is 1.
- R3: With `hw_gate_en`=0, `gate_open` follows `sw_gate` alone, and `hw_gate_pin` has no effect on the gate or on counting.
- R4: A rising edge of `clk` where `gate_open`=1, `cnt_strobe`=1 and `load`=0 changes `count` by +1 when `cnt_down`=0 and by -1 when `cnt_down`=1.
- R5: While `gate_open`=0 and `load`=0, `count` holds its value and strobes are ignored.
- R6: The count wraps modulo 2^32: +1 from 0xFFFFFFFF gives 0, and -1 from 0 gives 0xFFFFFFFF.
- R7: `load`=1 at a rising edge sets `count` to `load_value`. This holds whatever the gate state, and load wins over a strobe in the same cycle.
- R8: `hw_gate_pin` reaches the gate through two flops. A level driven just before edge k shows on `gate_open` after edge k+1.
- R9: A rising edge on `latch_pin` copies into `latch_value` the count as it stood just before the third clock edge after the pin rose. `latch_event` is 1 for that one cycle.
- R10: `latch_value` changes only on a latch capture. A pin held high, or a falling pin, causes no further capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_gate | input | 1 | Software gate bit from the control register |
| hw_gate_en | input | 1 | Configuration: 1 includes the hardware gate pin in the internal gate |
| hw_gate_pin | input | 1 | Asynchronous hardware gate pin |
| latch_pin | input | 1 | Asynchronous latch pin, captures on its rising edge |
| cnt_strobe | input | 1 | One-cycle count request from the decoder |
| cnt_down | input | 1 | Direction of the strobe: 1 counts down |
| load | input | 1 | Synchronous preset request |
| load_value | input | 32 | Start value for the preset |
| count | output | 32 | Live count |
| latch_value | output | 32 | Count captured by the last latch edge |
| latch_event | output | 1 | One-cycle pulse in the cycle a capture lands |
| gate_open | output | 1 | Current internal gate state |

## Verification
The hardest case is a capture taken while the count is moving. Only the exact cycle of the capture, set by the synchronizer depth and the edge detector, yields the expected snapshot, and a one-cycle offset still gives a plausible-looking value. The stimulus counts up on every cycle while the latch pin rises, so each cycle of skew gives a different captured value. It then holds the pin high and drops it while counting continues, which shows that no second capture occurs. A bench model of the hardware gate, with its own two-stage delay, likewise checks the exact cycle in which strobes start and stop being honoured.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2,
    ACT_LOAD = 2'd3
  } cnt_act_e;

  // Load has priority; a strobe only counts through an open gate.
  function automatic cnt_act_e pick_act(input logic ld, input logic strb,
                                        input logic gate, input logic dn);
    if (ld)                return ACT_LOAD;
    else if (strb && gate) return dn ? ACT_DOWN : ACT_UP;
    else                   return ACT_HOLD;
  endfunction
endpackage

// File: rtl/gcc_sync.sv
module gcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gcc_rise.sv
module gcc_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/gcc_gate.sv
module gcc_gate (
  input  logic sw_open,
  input  logic hw_level,
  input  logic hw_used,
  output logic gate
);
  // Hardware level counts only when configured in.
  logic hw_term;
  assign hw_term = hw_level | ~hw_used;
  assign gate    = sw_open & hw_term;
endmodule

// File: rtl/gcc_core.sv
module gcc_core
  import gcc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_act_e     act,
  input  logic [W-1:0] preset,
  input  logic         snap,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] snap_q,
  output logic         snap_evt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: cnt_q <= preset;
        ACT_UP:   cnt_q <= cnt_q + ONE;
        ACT_DOWN: cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q   <= '0;
      snap_evt <= 1'b0;
    end else begin
      snap_evt <= snap;
      if (snap) snap_q <= cnt_q;
    end
  end
endmodule

// File: rtl/gated_counter_channel.sv
module gated_counter_channel
  import gcc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_gate,
  input  logic             hw_gate_en,
  input  logic             hw_gate_pin,
  input  logic             latch_pin,
  input  logic             cnt_strobe,
  input  logic             cnt_down,
  input  logic             load,
  input  logic [CNT_W-1:0] load_value,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] latch_value,
  output logic             latch_event,
  output logic             gate_open
);
  logic     hw_s, latch_s, latch_rise;
  cnt_act_e act;

  gcc_sync #(.STAGES(SYNC_STAGES)) u_hw_sync (
    .clk(clk), .rst_n(rst_n), .din(hw_gate_pin), .dout(hw_s)
  );

  gcc_sync #(.STAGES(SYNC_STAGES)) u_latch_sync (
    .clk(clk), .rst_n(rst_n), .din(latch_pin), .dout(latch_s)
  );

  gcc_rise u_latch_edge (
    .clk(clk), .rst_n(rst_n), .level(latch_s), .rise(latch_rise)
  );

  gcc_gate u_gate (
    .sw_open(sw_gate), .hw_level(hw_s), .hw_used(hw_gate_en), .gate(gate_open)
  );

  assign act = pick_act(load, cnt_strobe, gate_open, cnt_down);

  gcc_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .act(act), .preset(load_value),
    .snap(latch_rise), .cnt_q(count), .snap_q(latch_value),
    .snap_evt(latch_event)
  );
endmodule

// File: rtl/gcc_checker.sv
module gcc_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_strobe,
  input logic         cnt_down,
  input logic         load,
  input logic [W-1:0] load_value,
  input logic         gate_open,
  input logic [W-1:0] count,
  input logic [W-1:0] latch_value,
  input logic         latch_event
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && cnt_strobe && !cnt_down && !load) |=> count == $past(count) + ONE);

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && cnt_strobe && cnt_down && !load) |=> count == $past(count) - ONE);

  a_r5_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !load) |=> count == $past(count));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_value));

  a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_event && $past(rst_n)) |-> latch_value == $past(count));

  a_r10_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_event && $past(rst_n)) |-> $stable(latch_value));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    latch_event |=> !latch_event);
endmodule

bind gated_counter_channel gcc_checker #(.W(CNT_W)) u_gcc_checker (
  .clk(clk), .rst_n(rst_n), .cnt_strobe(cnt_strobe), .cnt_down(cnt_down),
  .load(load), .load_value(load_value), .gate_open(gate_open), .count(count),
  .latch_value(latch_value), .latch_event(latch_event)
);

// File: tb/test_gated_counter_channel.sv
module test_gated_counter_channel;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_gate = 1'b0, hw_gate_en = 1'b0, hw_gate_pin = 1'b0, latch_pin = 1'b0;
  logic        cnt_strobe = 1'b0, cnt_down = 1'b0, load = 1'b0;
  logic [31:0] load_value = '0;
  logic [31:0] count, latch_value;
  logic        latch_event, gate_open;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] c;
    logic [31:0] l;
    logic        e;
    logic        g;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench model state
  logic        h1 = 0, h2 = 0, l1 = 0, l2 = 0, lprev = 0;
  logic [31:0] mc = '0, ml = '0;

  gated_counter_channel i_gated_counter_channel (
    .clk(clk), .rst_n(rst_n), .sw_gate(sw_gate), .hw_gate_en(hw_gate_en),
    .hw_gate_pin(hw_gate_pin), .latch_pin(latch_pin), .cnt_strobe(cnt_strobe),
    .cnt_down(cnt_down), .load(load), .load_value(load_value), .count(count),
    .latch_value(latch_value), .latch_event(latch_event), .gate_open(gate_open)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic step(input logic sw, input logic en, input logic hw, input logic lt,
                      input logic st, input logic dn, input logic ld,
                      input logic [31:0] lv, input string tag);
    exp_t  e;
    logic  g;
    logic  cap;
    @(negedge clk);
    sw_gate = sw; hw_gate_en = en; hw_gate_pin = hw; latch_pin = lt;
    cnt_strobe = st; cnt_down = dn; load = ld; load_value = lv;
    g   = sw & (h2 | ~en);
    cap = l2 & ~lprev;
    if (cap) ml = mc;
    if (ld)           mc = lv;
    else if (st && g) mc = dn ? mc - 32'd1 : mc + 32'd1;
    lprev = l2; l2 = l1; l1 = lt;
    h2 = h1; h1 = hw;
    e.c = mc; e.l = ml; e.e = cap; e.g = sw & (h2 | ~en); e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pops one expected item per clock, after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        vecs++;
        if (count !== e.c || latch_value !== e.l || latch_event !== e.e || gate_open !== e.g) begin
          bad++;
          $display("FAIL %s: count=%h latch=%h evt=%b gate=%b expected count=%h latch=%h evt=%b gate=%b",
                   e.tag, count, latch_value, latch_event, gate_open, e.c, e.l, e.e, e.g);
        end
      end
    end
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    vecs++;
    if (count !== 0 || latch_value !== 0 || latch_event !== 0) begin
      bad++;
      $display("FAIL R1: count=%h latch=%h evt=%b expected 0 0 0", count, latch_value, latch_event);
    end
    rst_n = 1'b1;
    step(0, 1, 0, 0, 0, 0, 0, 0, "R1");
    // R2/R5: sw open, hw low -> closed, strobes ignored
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 0, 0, 0, "R5");
    // R8: raise hw pin; gate opens two edges later; strobes track it
    step(1, 1, 1, 0, 1, 0, 0, 0, "R8");
    step(1, 1, 1, 0, 1, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 2; i++) step(1, 1, 1, 0, 1, 1, 0, 0, "R4");
    // R2: sw closed with hw high
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 1, 0, 0, 0, "R2");
    // R2: hw falls while sw open
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 1, 0, 0, 0, "R2");
    // R3: hw evaluation off, hw pin toggling has no effect
    for (int i = 0; i < 6; i++) step(1, 0, logic'(i % 2), 0, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 1, 0, 0, 0, "R3");
    // R7: load with gate closed, then load beside a strobe
    step(0, 0, 0, 0, 0, 0, 1, 32'h1234_5678, "R7");
    step(1, 0, 0, 0, 1, 1, 1, 32'h0000_0100, "R7");
    // R6: wrap both ways
    step(1, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R6");
    step(1, 0, 0, 0, 1, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 1, 1, 0, 0, "R6");
    step(1, 0, 0, 0, 1, 1, 0, 0, "R6");
    // R9: latch while counting every cycle
    step(1, 0, 0, 0, 0, 0, 1, 32'h0000_1000, "R9");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 1, 0, 0, 0, "R9");
    // R10: pin held high then dropped, no recapture
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 1, 0, 0, 0, "R10");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 1, 0, 0, 0, "R10");
    // R9: second capture with gate closed (counter still)
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    wait (sb.size() == 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule